// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a fixed-point multiply-accumulate datapath. On every cycle in which the valid strobe is high it takes a signed coefficient and a signed sample, multiplies them and adds the product into a wide accumulator register. One product is absorbed per accepted pair, so the sum of n products is on the output one cycle after the n-th pair. The accumulate step never wraps. A result above the largest representable value is replaced by that value, and a result below the smallest is replaced by the minimum. A sticky flag records that some step has clamped since the last clear.

A clear strobe that goes with an operand pair starts a new sum: the accumulator is loaded with that pair's result instead of adding it to the old value. A second mode turns the unit into a saturating adder/subtracter on signed bytes. It uses the low byte of each operand and keeps an 8-bit running result in the same register. Clamping happens at every step, so the final value depends on the order of the operations.

Top module: `sat_mac`

## Requirements
- R1: In multiply mode (`mode_i`=0), each pair accepted with `vld_i`=1 and `clr_i`=0 adds the signed product `a_i*b_i` to the accumulator. The new value appears on `acc_o` one cycle after the pair.
- R2: A pair accepted with `clr_i`=1 loads the accumulator with that pair's own result (the product, or in byte mode the result of combining the two byte operands) instead of combining it with the previous value.
- R3: In multiply mode, a sum above 2^(ACC_W-1)-1 becomes 2^(ACC_W-1)-1, and a sum below -2^(ACC_W-1) becomes -2^(ACC_W-1).
- R4: In byte mode (`mode_i`=1) the result is `x + b_i[7:0]` when `sub_i`=0 and `x - b_i[7:0]` when `sub_i`=1, clamped to [-128,127] and sign-extended onto `acc_o`. Here x is `a_i[7:0]` on a clear and the previous byte result otherwise. With a clear, 64+69 gives 127 and -127-5 gives -128.
- R5: Clamping is applied at each step. A clear with 64+70 followed by subtracting 25 gives 102, not 109.
- R6: `sat_o` becomes 1 on any step that clamps. It stays 1 until a pair accepted with `clr_i`=1, which sets it to whether that step itself clamped.
- R7: `vld_o` is 1 exactly in the cycle after each accepted pair, and 0 otherwise.
- R8: While `vld_i`=0, `acc_o` and `sat_o` hold their values. `clr_i` has no effect without `vld_i`.
- R9: After reset, `acc_o`=0, `vld_o`=0 and `sat_o`=0.
- R10: In byte mode without a clear, a previous accumulator value outside [-128,127] is first clamped to the byte range, and this counts as a clamp for `sat_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Start a new sum with the current pair |
| vld_i | input | 1 | Operand pair valid |
| mode_i | input | 1 | 0 multiply-accumulate, 1 byte add/subtract |
| sub_i | input | 1 | Byte mode: 1 subtract, 0 add |
| a_i | input | OP_W | Signed coefficient / first byte operand |
| b_i | input | OP_W | Signed sample / second byte operand |
| acc_o | output | ACC_W | Signed accumulator |
| vld_o | output | 1 | Result updated in the previous cycle |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
Five properties are checked on every cycle:
- the one-cycle lag of `vld_o`;
- that idle cycles and an unaccompanied clear leave the result and the flag untouched;
- that the flag only falls on a clear;
- that a byte-mode result stays inside [-128,127];
- that a non-negative product never moves an accumulator pinned at its maximum.

The bench scenarios are needed for the arithmetic itself: the exact products and running sums, the clamp to both accumulator limits after long runs, the listed byte cases, and the order dependence of (64+70)-25. They also cover the clearing of the flag by a new sum and the clamp of a wide value on a switch into byte mode.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic {
    MODE_MAC  = 1'b0,
    MODE_BYTE = 1'b1
  } mac_mode_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/sat_mac_rst_sync.sv
module sat_mac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/sat_mac_mul.sv
module sat_mac_mul #(
  parameter int OP_W = 16,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic signed [OP_W-1:0]   a_i,
  input  logic signed [OP_W-1:0]   b_i,
  output logic signed [PROD_W-1:0] prod_o
);
  always_comb begin
    prod_o = a_i * b_i;
  end
endmodule

// File: rtl/sat_mac_narrow.sv
module sat_mac_narrow #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  val_i,
  output logic signed [OUT_W-1:0] val_o,
  output logic                    clamp_o
);
  localparam int PAD_W = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] MAXV = {{PAD_W{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = {{PAD_W{1'b1}}, {(OUT_W-1){1'b0}}};

  logic above, below;

  always_comb begin
    above = val_i > MAXV;
    below = val_i < MINV;
    if (above)      val_o = MAXV[OUT_W-1:0];
    else if (below) val_o = MINV[OUT_W-1:0];
    else            val_o = val_i[OUT_W-1:0];
    clamp_o = above | below;
  end
endmodule

// File: rtl/sat_mac_addsat.sv
module sat_mac_addsat #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic                sub_i,
  output logic signed [W-1:0] sum_o,
  output logic                clamp_o
);
  localparam int EXT_W = W + 1;

  logic signed [EXT_W-1:0] x_ext, y_ext, raw;

  always_comb begin
    x_ext = EXT_W'(x_i);
    y_ext = EXT_W'(y_i);
    raw   = sub_i ? (x_ext - y_ext) : (x_ext + y_ext);
  end

  sat_mac_narrow #(.IN_W(EXT_W), .OUT_W(W)) u_narrow (
    .val_i  (raw),
    .val_o  (sum_o),
    .clamp_o(clamp_o)
  );
endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    vld_i,
  input  logic                    mode_i,
  input  logic                    sub_i,
  input  logic signed [OP_W-1:0]  a_i,
  input  logic signed [OP_W-1:0]  b_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic                    vld_o,
  output logic                    sat_o
);
  localparam int PROD_W = 2 * OP_W;

  logic rst_n_s;

  // product path
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, mac_base, mac_sum;
  logic                     mac_clamp;

  // byte path
  logic signed [BYTE_W-1:0] old_byte, byte_base, byte_sum;
  logic                     old_clamp, byte_clamp;

  // state
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    sat_q, sat_d;
  logic                    vld_q;
  logic                    step_clamp;
  mac_mode_e               mode;

  sat_mac_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_n_s(rst_n_s)
  );

  sat_mac_mul #(.OP_W(OP_W)) u_mul (
    .a_i   (a_i),
    .b_i   (b_i),
    .prod_o(prod)
  );

  always_comb begin
    prod_ext = ACC_W'(prod);
    mac_base = clr_i ? '0 : acc_q;
  end

  sat_mac_addsat #(.W(ACC_W)) u_mac_add (
    .x_i    (mac_base),
    .y_i    (prod_ext),
    .sub_i  (1'b0),
    .sum_o  (mac_sum),
    .clamp_o(mac_clamp)
  );

  sat_mac_narrow #(.IN_W(ACC_W), .OUT_W(BYTE_W)) u_old_narrow (
    .val_i  (acc_q),
    .val_o  (old_byte),
    .clamp_o(old_clamp)
  );

  always_comb begin
    byte_base = clr_i ? a_i[BYTE_W-1:0] : old_byte;
  end

  sat_mac_addsat #(.W(BYTE_W)) u_byte_add (
    .x_i    (byte_base),
    .y_i    (b_i[BYTE_W-1:0]),
    .sub_i  (sub_i),
    .sum_o  (byte_sum),
    .clamp_o(byte_clamp)
  );

  // next-state
  always_comb begin
    mode       = mac_mode_e'(mode_i);
    acc_d      = acc_q;
    sat_d      = sat_q;
    step_clamp = 1'b0;
    if (vld_i) begin
      if (mode == MODE_BYTE) begin
        acc_d      = ACC_W'(byte_sum);
        step_clamp = byte_clamp | (old_clamp & ~clr_i);
      end else begin
        acc_d      = mac_sum;
        step_clamp = mac_clamp;
      end
      sat_d = clr_i ? step_clamp : (sat_q | step_clamp);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc_q <= '0;
      sat_q <= 1'b0;
    end else if (vld_i) begin
      acc_q <= acc_d;
      sat_q <= sat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) vld_q <= 1'b0;
    else          vld_q <= vld_i;
  end

  assign acc_o = acc_q;
  assign sat_o = sat_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr_i,
  input logic                    vld_i,
  input logic                    mode_i,
  input logic signed [OP_W-1:0]  a_i,
  input logic signed [OP_W-1:0]  b_i,
  input logic signed [ACC_W-1:0] acc_o,
  input logic                    vld_o,
  input logic                    sat_o
);
  localparam logic signed [ACC_W-1:0] TOPV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] BMAX = ACC_W'(127);
  localparam logic signed [ACC_W-1:0] BMIN = -ACC_W'(128);

  // R7
  vld_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);

  // R7
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(acc_o) && $stable(sat_o)));

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !(vld_i && clr_i)) |=> sat_o);

  // R4
  byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && mode_i) |=> (acc_o <= BMAX && acc_o >= BMIN));

  // R3
  pinned_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !clr_i && !mode_i && acc_o == TOPV && ((a_i < 0) == (b_i < 0)))
    |=> (acc_o == TOPV));
endmodule

bind sat_mac sat_mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n_s),
  .clr_i (clr_i),
  .vld_i (vld_i),
  .mode_i(mode_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .acc_o (acc_o),
  .vld_o (vld_o),
  .sat_o (sat_o)
);

// File: tb/sim_sat_mac.sv
module sim_sat_mac;
  localparam int OP_W  = 16;
  localparam int ACC_W = 40;

  typedef struct {
    longint acc;
    bit     sat;
    string  tag;
  } exp_t;

  logic clk, rst_n, clr_i, vld_i, mode_i, sub_i;
  logic signed [OP_W-1:0]  a_i, b_i;
  logic signed [ACC_W-1:0] acc_o;
  logic vld_o, sat_o;

  int n_chk = 0, n_bad = 0;
  exp_t q[$];
  longint m_acc = 0;
  bit     m_sat = 0;
  bit     mon_on = 0;

  sat_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_i(vld_i), .mode_i(mode_i),
    .sub_i(sub_i), .a_i(a_i), .b_i(b_i), .acc_o(acc_o), .vld_o(vld_o), .sat_o(sat_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint clampw(longint v, int w);
    longint mx = (longint'(1) << (w - 1)) - 1;
    longint mn = -(longint'(1) << (w - 1));
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: model the step, queue the expectation, drive the pair
  task automatic op(bit clr, bit md, bit sb, int a, int b, string tag);
    longint s, r, x, old;
    bit cl = 0;
    logic signed [7:0] a8, b8;
    a8 = a[7:0];
    b8 = b[7:0];
    if (md) begin
      old = clampw(m_acc, 8);
      if (!clr && old != m_acc) cl = 1;
      x = clr ? longint'(a8) : old;
      s = sb ? x - longint'(b8) : x + longint'(b8);
    end else begin
      s = (clr ? 0 : m_acc) + longint'(a) * longint'(b);
    end
    r = clampw(s, md ? 8 : ACC_W);
    if (r != s) cl = 1;
    m_acc = r;
    m_sat = clr ? cl : (m_sat | cl);
    q.push_back('{acc: m_acc, sat: m_sat, tag: tag});
    @(negedge clk);
    clr_i = clr; mode_i = md; sub_i = sb;
    a_i = OP_W'(a); b_i = OP_W'(b); vld_i = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld_i = 1'b0; clr_i = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on && vld_o) begin
      if (q.size() == 0) begin
        check(0, "R7 unexpected vld_o", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(longint'(acc_o) == e.acc, e.tag, longint'(acc_o), e.acc);
        check(sat_o == e.sat, {e.tag, " R6 flag"}, longint'(sat_o), longint'(e.sat));
      end
    end
  end

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; clr_i = 0; vld_i = 0; mode_i = 0; sub_i = 0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R9
    check(acc_o == '0, "R9 acc", longint'(acc_o), 0);
    check(vld_o == 1'b0, "R9 vld", longint'(vld_o), 0);
    check(sat_o == 1'b0, "R9 sat", longint'(sat_o), 0);
    mon_on = 1;

    // R1, R2: running sum of products
    op(1, 0, 0, 3, 4, "R2 clear load");
    op(0, 0, 0, -5, 7, "R1 accumulate");
    op(0, 0, 0, 1000, -200, "R1 accumulate");
    op(0, 0, 0, -32768, -32768, "R1 largest product");
    op(1, 0, 0, 9, 9, "R2 new sum");
    idle(3);

    // R8: idle hold and ignored clear
    check(longint'(acc_o) == m_acc, "R8 hold", longint'(acc_o), m_acc);
    @(negedge clk); clr_i = 1; vld_i = 0; a_i = 16'sd100; b_i = 16'sd100;
    @(negedge clk); clr_i = 0;
    check(longint'(acc_o) == m_acc, "R8 clear ignored", longint'(acc_o), m_acc);
    check(vld_o == 1'b0, "R7 idle vld", longint'(vld_o), 0);
    op(0, 0, 0, 1, 1, "R8 sum continues");
    idle(2);

    // R3: positive clamp, then negative clamp
    op(1, 0, 0, -32768, -32768, "R3 up start");
    for (int i = 0; i < 520; i++) op(0, 0, 0, -32768, -32768, "R3 upper limit");
    op(0, 0, 0, 2, 3, "R6 sticky after clamp");
    for (int i = 0; i < 1030; i++) op(0, 0, 0, -32768, 32767, "R3 lower limit");
    idle(2);
    check(longint'(acc_o) == -(longint'(1) << 39), "R3 final min", longint'(acc_o), -(longint'(1) << 39));
    check(sat_o == 1'b1, "R6 still set", longint'(sat_o), 1);

    // R10: switch to byte mode with wide value
    op(0, 1, 0, 0, 1, "R10 narrow old");
    // R6: clear drops flag
    op(1, 0, 0, 2, 2, "R6 clear drops flag");
    idle(2);

    // R4: byte cases
    op(1, 1, 0, 64, 69, "R4 64+69");
    op(1, 1, 1, -127, 5, "R4 -127-5");
    op(1, 1, 0, 10, -20, "R4 10+-20");
    op(0, 1, 1, 0, 30, "R4 sub chain");
    // R5: order dependence
    op(1, 1, 0, 64, 70, "R5 64+70");
    op(0, 1, 1, 0, 25, "R5 then -25");
    idle(3);
    check(longint'(acc_o) == 102, "R5 result", longint'(acc_o), 102);
    op(1, 1, 0, 64, 45, "R5 70-25 first");
    idle(3);
    check(longint'(acc_o) == 109, "R5 other order", longint'(acc_o), 109);
    check(q.size() == 0, "R7 all results seen", q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule